// File: doc/BRIEF.md
# Debug ROM Hart-Parking Sequencer

This block is the fetch-side model of a small debug memory region that halted harts run from. It holds four word windows: a per-hart entry table, a short code window, a program-buffer RAM and an exception window. Instruction fetches arriving on a simple word-wide memory port are served from these windows, and some fetches have side effects. A fetch from the entry table marks a hart as parked. A fetch that finds the selected hart's slot looping on itself ends the running command. A fetch that finds the code window holding a debug-return instruction resumes the selected hart. A fetch from the exception window records a fault.

A separate command generator writes the entry table, the code window and the exception window through a table write port. It also queues a pending action, raises the busy flag and posts its own error codes. When a hart fetches a queued action from its slot, the block remembers this. On the next fetch from any other mapped window, it loads the pending action into the selected hart's slot and returns the pending action to the self-loop. All words are little-endian: byte lane 0 is bits 7:0.

Top module: `dbgrom_park_seq`

## Requirements
- R1: After reset, all halted flags are 0, busy is 0 and the error code is 0 (none). Every entry-table slot reads 0x0000006F (the self-loop jump). Every program-buffer, code and exception word reads 0.
- R2: A word-aligned read at entry-table byte offset 4*h returns slot h one cycle after the request, with the response valid and no error. On the cycle after the request, halted[h] is 1.
- R3: busy_set makes busy 1 on the next cycle, and it wins over any clearing in the same cycle. An entry-table read while slot[sel_hart] holds 0x0000006F clears busy.
- R4: An entry-table read while slot[sel_hart] holds any other word arms a marker. The next read from a mapped window other than the entry table copies the pending action into slot[sel_hart], sets the pending action back to 0x0000006F and disarms the marker. The read that does this still returns the data of the window it addresses.
- R5: A code-window read while code word 0 holds 0x7B200073 (debug return) clears busy and clears halted[sel_hart].
- R6: An exception-window read sets the error code to 3 (exception), but only when it is 0. cmd_err_valid loads cmd_err_code, also only when the code is 0. err_clr sets the code to 0 and wins over both. A nonzero code is otherwise never changed.
- R7: A write to the program buffer updates only the bytes whose m_be bit is set. m_be[k] covers bits 8k+7:8k.
- R8: A request that is misaligned, falls outside every window, or writes anything other than the program buffer gets an error response with data 0. It changes no halted flag, no window word, no marker and no pending action.
- R9: tw_we writes tw_data to word tw_idx of the window chosen by tw_win: 0 for the entry table, 1 for the code window, 2 for the exception window. tw_win 3 writes nothing. A table write to slot[sel_hart] wins over a restore in the same cycle.
- R10: nxt_we loads the pending action and wins over the reset to self-loop done by a restore in the same cycle.
- R11: The halted flags change only through R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Memory request |
| m_we | input | 1 | 1 = write, 0 = read/fetch |
| m_addr | input | AW | Byte address within the region |
| m_be | input | 4 | Byte enables for writes |
| m_wdata | input | 32 | Write data |
| m_rvalid | output | 1 | Response valid, one cycle after m_req |
| m_rdata | output | 32 | Read data |
| m_err | output | 1 | Error response |
| sel_hart | input | HART_W | Hart currently selected by the host |
| tw_we | input | 1 | Table write strobe |
| tw_win | input | 2 | Target window of the table write |
| tw_idx | input | IDX_W | Word index of the table write |
| tw_data | input | 32 | Table write data |
| nxt_we | input | 1 | Load pending action |
| nxt_data | input | 32 | Pending action word |
| busy_set | input | 1 | Command launched; set busy |
| cmd_err_valid | input | 1 | Post command error |
| cmd_err_code | input | 3 | Posted error code |
| err_clr | input | 1 | Clear error code |
| halted | output | NUM_HARTS | Per-hart halted flags |
| busy | output | 1 | Command in progress |
| err_code | output | 3 | Sticky error code |

## Verification
The bench builds the block with four harts, a two-word code window, an eight-word program buffer and a four-word exception window, placed at byte bases 0x000, 0x100, 0x200 and 0x300 with a 12-bit address. Four harts let the checks give separate harts distinct parked, resumed and selected roles. The two-word code window lets a fetch of word 1 trigger a restore without matching the debug-return check on word 0. The eight-word buffer leaves room to test byte-lane writes on one word while other words stay at zero. The address width leaves unmapped space above 0x300 for the error-response checks.

// File: rtl/dbgrom_pkg.sv
package dbgrom_pkg;
   localparam logic [31:0] INSN_SELF_LOOP = 32'h0000_006F;
   localparam logic [31:0] INSN_DEBUG_RET = 32'h7B20_0073;

   typedef enum logic [2:0] {
      ERR_NONE        = 3'd0,
      ERR_BUSY        = 3'd1,
      ERR_UNSUPPORTED = 3'd2,
      ERR_EXCEPTION   = 3'd3,
      ERR_HALT_RESUME = 3'd4,
      ERR_OTHER       = 3'd7
   } err_e;

   // window selector, shared by the address decoder and the table write port
   typedef enum logic [1:0] {
      WIN_ENTRY = 2'd0,
      WIN_CODE  = 2'd1,
      WIN_EXC   = 2'd2,
      WIN_PBUF  = 2'd3
   } win_e;
endpackage

// File: rtl/dbgrom_decode.sv
module dbgrom_decode
   import dbgrom_pkg::*;
#(
   parameter int AW         = 12,
   parameter int ENTRY_BASE = 'h000,
   parameter int NUM_HARTS  = 4,
   parameter int CODE_BASE  = 'h100,
   parameter int CODE_WORDS = 2,
   parameter int PBUF_BASE  = 'h200,
   parameter int PBUF_WORDS = 8,
   parameter int EXC_BASE   = 'h300,
   parameter int EXC_WORDS  = 4,
   parameter int IW         = 3
) (
   input  logic [AW-1:0] addr,
   output logic          hit,
   output win_e          win,
   output logic [IW-1:0] idx
);
   localparam logic [31:0] E_LO = 32'(ENTRY_BASE);
   localparam logic [31:0] E_HI = 32'(ENTRY_BASE + 4*NUM_HARTS);
   localparam logic [31:0] C_LO = 32'(CODE_BASE);
   localparam logic [31:0] C_HI = 32'(CODE_BASE + 4*CODE_WORDS);
   localparam logic [31:0] P_LO = 32'(PBUF_BASE);
   localparam logic [31:0] P_HI = 32'(PBUF_BASE + 4*PBUF_WORDS);
   localparam logic [31:0] X_LO = 32'(EXC_BASE);
   localparam logic [31:0] X_HI = 32'(EXC_BASE + 4*EXC_WORDS);

   logic [31:0] a_ext;
   logic        aligned;

   assign a_ext   = 32'(addr);
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      hit = 1'b0;
      win = WIN_ENTRY;
      idx = '0;
      if (aligned) begin
         if (a_ext >= E_LO && a_ext < E_HI) begin
            hit = 1'b1; win = WIN_ENTRY; idx = IW'((a_ext - E_LO) >> 2);
         end else if (a_ext >= C_LO && a_ext < C_HI) begin
            hit = 1'b1; win = WIN_CODE;  idx = IW'((a_ext - C_LO) >> 2);
         end else if (a_ext >= P_LO && a_ext < P_HI) begin
            hit = 1'b1; win = WIN_PBUF;  idx = IW'((a_ext - P_LO) >> 2);
         end else if (a_ext >= X_LO && a_ext < X_HI) begin
            hit = 1'b1; win = WIN_EXC;   idx = IW'((a_ext - X_LO) >> 2);
         end
      end
   end
endmodule

// File: rtl/dbgrom_wordmem.sv
module dbgrom_wordmem #(
   parameter int          WORDS    = 4,
   parameter int          IW       = 2,
   parameter logic [31:0] RST_WORD = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   // port a has priority over port b on every byte
   input  logic          a_we,
   input  logic [IW-1:0] a_idx,
   input  logic [3:0]    a_be,
   input  logic [31:0]   a_data,
   input  logic          b_we,
   input  logic [IW-1:0] b_idx,
   input  logic [3:0]    b_be,
   input  logic [31:0]   b_data,
   output logic [31:0]   words_o [WORDS]
);
   if (WORDS < 1) begin : g_bad_words
      $error("dbgrom_wordmem: WORDS must be at least 1");
   end
   if ((1 << IW) < WORDS) begin : g_bad_iw
      $error("dbgrom_wordmem: IW too narrow for WORDS");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= RST_WORD;
         end else begin
            for (int b = 0; b < 4; b++) begin
               if (a_we && a_idx == IW'(w) && a_be[b])
                  word_q[8*b +: 8] <= a_data[8*b +: 8];
               else if (b_we && b_idx == IW'(w) && b_be[b])
                  word_q[8*b +: 8] <= b_data[8*b +: 8];
            end
         end
      end
      assign words_o[w] = word_q;
   end

   assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we || b_we) |-> ((!a_we || 32'(a_idx) < WORDS) && (!b_we || 32'(b_idx) < WORDS)));
endmodule

// File: rtl/dbgrom_park_seq.sv
module dbgrom_park_seq
   import dbgrom_pkg::*;
#(
   parameter int AW         = 12,
   parameter int NUM_HARTS  = 4,
   parameter int ENTRY_BASE = 'h000,
   parameter int CODE_BASE  = 'h100,
   parameter int CODE_WORDS = 2,
   parameter int PBUF_BASE  = 'h200,
   parameter int PBUF_WORDS = 8,
   parameter int EXC_BASE   = 'h300,
   parameter int EXC_WORDS  = 4,
   localparam int MAX_A     = (NUM_HARTS > CODE_WORDS) ? NUM_HARTS : CODE_WORDS,
   localparam int MAX_B     = (PBUF_WORDS > EXC_WORDS) ? PBUF_WORDS : EXC_WORDS,
   localparam int MAX_W     = (MAX_A > MAX_B) ? MAX_A : MAX_B,
   localparam int IDX_W     = (MAX_W > 1) ? $clog2(MAX_W) : 1,
   localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 m_req,
   input  logic                 m_we,
   input  logic [AW-1:0]        m_addr,
   input  logic [3:0]           m_be,
   input  logic [31:0]          m_wdata,
   output logic                 m_rvalid,
   output logic [31:0]          m_rdata,
   output logic                 m_err,
   input  logic [HART_W-1:0]    sel_hart,
   input  logic                 tw_we,
   input  logic [1:0]           tw_win,
   input  logic [IDX_W-1:0]     tw_idx,
   input  logic [31:0]          tw_data,
   input  logic                 nxt_we,
   input  logic [31:0]          nxt_data,
   input  logic                 busy_set,
   input  logic                 cmd_err_valid,
   input  logic [2:0]           cmd_err_code,
   input  logic                 err_clr,
   output logic [NUM_HARTS-1:0] halted,
   output logic                 busy,
   output logic [2:0]           err_code
);
   // ---------------- elaboration checks ----------------
   if (AW < 4 || AW > 24) begin : g_bad_aw
      $error("dbgrom_park_seq: AW out of range");
   end
   if (NUM_HARTS < 1 || CODE_WORDS < 1 || PBUF_WORDS < 1 || EXC_WORDS < 1) begin : g_bad_size
      $error("dbgrom_park_seq: every window needs at least one word");
   end
   if ((ENTRY_BASE | CODE_BASE | PBUF_BASE | EXC_BASE) % 4 != 0) begin : g_bad_align
      $error("dbgrom_park_seq: window bases must be word aligned");
   end
   if (ENTRY_BASE + 4*NUM_HARTS > CODE_BASE || CODE_BASE + 4*CODE_WORDS > PBUF_BASE ||
       PBUF_BASE + 4*PBUF_WORDS > EXC_BASE || EXC_BASE + 4*EXC_WORDS > (1 << AW)) begin : g_bad_map
      $error("dbgrom_park_seq: windows must ascend without overlap inside the address space");
   end

   // ---------------- decode ----------------
   logic             d_hit;
   win_e             d_win;
   logic [IDX_W-1:0] d_idx;

   dbgrom_decode #(
      .AW(AW), .ENTRY_BASE(ENTRY_BASE), .NUM_HARTS(NUM_HARTS),
      .CODE_BASE(CODE_BASE), .CODE_WORDS(CODE_WORDS),
      .PBUF_BASE(PBUF_BASE), .PBUF_WORDS(PBUF_WORDS),
      .EXC_BASE(EXC_BASE), .EXC_WORDS(EXC_WORDS), .IW(IDX_W)
   ) u_decode (
      .addr(m_addr), .hit(d_hit), .win(d_win), .idx(d_idx)
   );

   logic rd_ok, wr_ok, ent_fetch, other_fetch, code_fetch, exc_fetch;
   assign rd_ok       = m_req && !m_we && d_hit;
   assign wr_ok       = m_req &&  m_we && d_hit && (d_win == WIN_PBUF);
   assign ent_fetch   = rd_ok && (d_win == WIN_ENTRY);
   assign other_fetch = rd_ok && (d_win != WIN_ENTRY);
   assign code_fetch  = rd_ok && (d_win == WIN_CODE);
   assign exc_fetch   = rd_ok && (d_win == WIN_EXC);

   // ---------------- storage ----------------
   logic [31:0] ent_w  [NUM_HARTS];
   logic [31:0] code_w [CODE_WORDS];
   logic [31:0] pbuf_w [PBUF_WORDS];
   logic [31:0] exc_w  [EXC_WORDS];

   logic        marker_q;
   logic [31:0] pend_q;
   logic        restore;
   logic [31:0] sel_slot;
   logic        sel_is_loop;
   logic        dret_hit;

   assign sel_slot    = ent_w[sel_hart];
   assign sel_is_loop = (sel_slot == INSN_SELF_LOOP);
   assign restore     = other_fetch && marker_q;
   assign dret_hit    = code_fetch && (code_w[0] == INSN_DEBUG_RET);

   dbgrom_wordmem #(.WORDS(NUM_HARTS), .IW(IDX_W), .RST_WORD(INSN_SELF_LOOP)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .a_we(tw_we && tw_win == WIN_ENTRY), .a_idx(tw_idx), .a_be(4'hF), .a_data(tw_data),
      .b_we(restore), .b_idx(IDX_W'(sel_hart)), .b_be(4'hF), .b_data(pend_q),
      .words_o(ent_w)
   );

   dbgrom_wordmem #(.WORDS(CODE_WORDS), .IW(IDX_W), .RST_WORD(32'h0)) u_code (
      .clk(clk), .rst_n(rst_n),
      .a_we(tw_we && tw_win == WIN_CODE), .a_idx(tw_idx), .a_be(4'hF), .a_data(tw_data),
      .b_we(1'b0), .b_idx('0), .b_be(4'h0), .b_data(32'h0),
      .words_o(code_w)
   );

   dbgrom_wordmem #(.WORDS(PBUF_WORDS), .IW(IDX_W), .RST_WORD(32'h0)) u_pbuf (
      .clk(clk), .rst_n(rst_n),
      .a_we(wr_ok), .a_idx(d_idx), .a_be(m_be), .a_data(m_wdata),
      .b_we(1'b0), .b_idx('0), .b_be(4'h0), .b_data(32'h0),
      .words_o(pbuf_w)
   );

   dbgrom_wordmem #(.WORDS(EXC_WORDS), .IW(IDX_W), .RST_WORD(32'h0)) u_exc (
      .clk(clk), .rst_n(rst_n),
      .a_we(tw_we && tw_win == WIN_EXC), .a_idx(tw_idx), .a_be(4'hF), .a_data(tw_data),
      .b_we(1'b0), .b_idx('0), .b_be(4'h0), .b_data(32'h0),
      .words_o(exc_w)
   );

   // ---------------- read mux and response ----------------
   logic [31:0] rd_mux;
   always_comb begin
      unique case (d_win)
         WIN_ENTRY: rd_mux = ent_w[d_idx];
         WIN_CODE:  rd_mux = code_w[d_idx];
         WIN_PBUF:  rd_mux = pbuf_w[d_idx];
         default:   rd_mux = exc_w[d_idx];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rvalid <= 1'b0;
         m_rdata  <= '0;
         m_err    <= 1'b0;
      end else begin
         m_rvalid <= m_req;
         m_rdata  <= rd_ok ? rd_mux : '0;
         m_err    <= m_req && !(rd_ok || wr_ok);
      end
   end

   // ---------------- sequencing state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         marker_q <= 1'b0;
         pend_q   <= INSN_SELF_LOOP;
      end else begin
         if (restore)                       marker_q <= 1'b0;
         else if (ent_fetch && !sel_is_loop) marker_q <= 1'b1;
         if (nxt_we)       pend_q <= nxt_data;
         else if (restore) pend_q <= INSN_SELF_LOOP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      busy <= 1'b0;
      else if (busy_set)                               busy <= 1'b1;
      else if ((ent_fetch && sel_is_loop) || dret_hit) busy <= 1'b0;
   end

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                         halted[h] <= 1'b0;
         else if (ent_fetch && d_idx == IDX_W'(h))           halted[h] <= 1'b1;
         else if (dret_hit && sel_hart == HART_W'(h))        halted[h] <= 1'b0;
      end
   end

   err_e err_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                err_q <= ERR_NONE;
      else if (err_clr)          err_q <= ERR_NONE;
      else if (err_q == ERR_NONE) begin
         if (exc_fetch)          err_q <= ERR_EXCEPTION;
         else if (cmd_err_valid) err_q <= err_e'(cmd_err_code);
      end
   end
   assign err_code = err_q;

   // ---------------- assertions ----------------
   assert_rsp_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |=> m_rvalid);
   assert_entry_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ent_fetch |=> halted[$past(d_idx)]);
   assert_busy_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_set |=> busy);
   assert_restore_resets_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !nxt_we) |=> (pend_q == INSN_SELF_LOOP && !marker_q));
   assert_dret_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dret_hit && !busy_set) |=> !busy);
   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q != ERR_NONE && !err_clr) |=> $stable(err_q));
   assert_bad_access_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !rd_ok && !wr_ok && !nxt_we) |=>
         (m_err && $stable(halted) && $stable(marker_q) && $stable(pend_q)));
   assert_halted_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ent_fetch && !dret_hit) |=> $stable(halted));
endmodule

// File: tb/dbgrom_park_seq_tb.sv
module dbgrom_park_seq_tb;
   localparam int NH = 4, CW = 2, PW = 8, XW = 4, AW = 12;
   localparam int IW = 3, HW = 2;
   localparam logic [31:0] SELF = 32'h0000_006F;
   localparam logic [31:0] DRET = 32'h7B20_0073;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic m_req = 0, m_we = 0;
   logic [AW-1:0] m_addr = '0;
   logic [3:0] m_be = 0;
   logic [31:0] m_wdata = 0;
   logic m_rvalid, m_err;
   logic [31:0] m_rdata;
   logic [HW-1:0] sel_hart = 1;
   logic tw_we = 0; logic [1:0] tw_win = 0; logic [IW-1:0] tw_idx = 0; logic [31:0] tw_data = 0;
   logic nxt_we = 0; logic [31:0] nxt_data = 0;
   logic busy_set = 0, cmd_err_valid = 0, err_clr = 0;
   logic [2:0] cmd_err_code = 0;
   logic [NH-1:0] halted;
   logic busy;
   logic [2:0] err_code;

   dbgrom_park_seq #(.AW(AW), .NUM_HARTS(NH), .ENTRY_BASE('h000), .CODE_BASE('h100),
      .CODE_WORDS(CW), .PBUF_BASE('h200), .PBUF_WORDS(PW), .EXC_BASE('h300), .EXC_WORDS(XW)
   ) u_dut (.*);

   int n_tests = 0, n_fail = 0;
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] me [NH]; logic [31:0] mc [CW]; logic [31:0] mp [PW]; logic [31:0] mx [XW];
   logic [31:0] mpend; logic mmark; logic [NH-1:0] mh; logic mb; logic [2:0] merr;
   logic erv, eer; logic [31:0] erd;
   int w, ix; logic bclr, xhit, ok; logic [31:0] rd;

   task automatic locate(input int a, output int win, output int idx);
      win = -1; idx = 0;
      if (a % 4 == 0) begin
         if (a < 4*NH)                          begin win = 0; idx = a/4; end
         else if (a >= 'h100 && a < 'h100+4*CW) begin win = 1; idx = (a-'h100)/4; end
         else if (a >= 'h200 && a < 'h200+4*PW) begin win = 2; idx = (a-'h200)/4; end
         else if (a >= 'h300 && a < 'h300+4*XW) begin win = 3; idx = (a-'h300)/4; end
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NH; i++) me[i] = SELF;
         for (int i = 0; i < CW; i++) mc[i] = 0;
         for (int i = 0; i < PW; i++) mp[i] = 0;
         for (int i = 0; i < XW; i++) mx[i] = 0;
         mpend = SELF; mmark = 0; mh = 0; mb = 0; merr = 0; erv = 0; erd = 0; eer = 0;
      end else begin
         locate(int'(m_addr), w, ix);
         bclr = 0; xhit = 0; ok = 0; rd = 0;
         if (m_req && !m_we && w >= 0) begin
            ok = 1;
            if (w == 0) begin
               rd = me[ix]; mh[ix] = 1'b1;
               if (me[sel_hart] == SELF) bclr = 1; else mmark = 1;
            end else begin
               if (mmark) begin me[sel_hart] = mpend; mpend = SELF; mmark = 0; end
               if (w == 1) begin
                  rd = mc[ix];
                  if (mc[0] == DRET) begin bclr = 1; mh[sel_hart] = 1'b0; end
               end else if (w == 2) rd = mp[ix];
               else begin rd = mx[ix]; xhit = 1; end
            end
         end
         if (m_req && m_we && w == 2) begin
            ok = 1;
            for (int b = 0; b < 4; b++) if (m_be[b]) mp[ix][8*b +: 8] = m_wdata[8*b +: 8];
         end
         if (tw_we) begin
            if (tw_win == 0) me[tw_idx] = tw_data;
            else if (tw_win == 1) mc[tw_idx] = tw_data;
            else if (tw_win == 2) mx[tw_idx] = tw_data;
         end
         if (nxt_we) mpend = nxt_data;
         if (busy_set) mb = 1; else if (bclr) mb = 0;
         if (err_clr) merr = 0;
         else if (merr == 0) begin
            if (xhit) merr = 3; else if (cmd_err_valid) merr = cmd_err_code;
         end
         erv = m_req; erd = rd; eer = m_req && !ok;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R11 halted vs model", 32'(halted), 32'(mh));
         chk("R3 busy vs model", 32'(busy), 32'(mb));
         chk("R6 err_code vs model", 32'(err_code), 32'(merr));
         chk("R2 rvalid vs model", 32'(m_rvalid), 32'(erv));
         chk("R2 rdata vs model", m_rdata, erd);
         chk("R8 m_err vs model", 32'(m_err), 32'(eer));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk); m_req = 1; m_we = 0; m_addr = AW'(a);
      @(negedge clk); m_req = 0;
      chk(tag, m_rdata, exp);
      chk(tag, 32'(m_err), 32'(0));
   endtask
   task automatic bad_req(input logic we, input int a, input string tag);
      @(negedge clk); m_req = 1; m_we = we; m_addr = AW'(a); m_be = 4'hF; m_wdata = 32'hFFFF_FFFF;
      @(negedge clk); m_req = 0; m_we = 0;
      chk(tag, 32'(m_err), 32'(1));
      chk(tag, m_rdata, 32'h0);
   endtask
   task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk); m_req = 1; m_we = 1; m_addr = AW'(a); m_be = be; m_wdata = d;
      @(negedge clk); m_req = 0; m_we = 0;
      chk("R7 pbuf write accepted", 32'(m_err), 32'(0));
   endtask
   task automatic tw(input logic [1:0] win, input int idx, input logic [31:0] d);
      @(negedge clk); tw_we = 1; tw_win = win; tw_idx = IW'(idx); tw_data = d;
      @(negedge clk); tw_we = 0;
   endtask
   task automatic nxt(input logic [31:0] d);
      @(negedge clk); nxt_we = 1; nxt_data = d;
      @(negedge clk); nxt_we = 0;
   endtask
   task automatic bset();
      @(negedge clk); busy_set = 1;
      @(negedge clk); busy_set = 0;
   endtask
   task automatic ecmd(input logic [2:0] c);
      @(negedge clk); cmd_err_valid = 1; cmd_err_code = c;
      @(negedge clk); cmd_err_valid = 0;
   endtask
   task automatic eclr();
      @(negedge clk); err_clr = 1;
      @(negedge clk); err_clr = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 halted after reset", 32'(halted), 32'h0);
      chk("R1 busy after reset", 32'(busy), 32'h0);
      chk("R1 err after reset", 32'(err_code), 32'h0);
      rd_chk('h008, SELF, "R1 entry slot 2 self-loop");
      chk("R2 fetch parks hart 2", 32'(halted), 32'h4);
      rd_chk('h21C, 32'h0, "R1 pbuf zeroed");
      rd_chk('h304, 32'h0, "R1 exc zeroed");

      // R3 self-loop fetch ends command
      sel_hart = 1;
      bset();
      chk("R3 busy set", 32'(busy), 32'h1);
      rd_chk('h004, SELF, "R2 entry slot 1");
      chk("R3 self-loop clears busy", 32'(busy), 32'h0);
      chk("R2 hart 1 parked", 32'(halted), 32'h6);

      // R4 queued action and restore
      tw(2'd0, 1, 32'h1234_5678);
      nxt(32'hAABB_CCDD);
      bset();
      rd_chk('h004, 32'h1234_5678, "R4 queued action fetched");
      chk("R4 busy kept on action", 32'(busy), 32'h1);
      rd_chk('h200, 32'h0, "R4 restore fetch returns own data");
      rd_chk('h004, 32'hAABB_CCDD, "R4 slot holds pending action");

      // R8 bad accesses while armed
      bad_req(1'b0, 'h400, "R8 unmapped read");
      bad_req(1'b0, 'h102, "R8 misaligned read");
      bad_req(1'b1, 'h004, "R8 write to entry table");
      rd_chk('h004, 32'hAABB_CCDD, "R8 no restore and no write");
      rd_chk('h104, 32'h0, "R4 code fetch restores");
      rd_chk('h004, SELF, "R4 pending reset to self-loop");
      chk("R4 busy cleared after restore", 32'(busy), 32'h0);

      // R5 debug return
      tw(2'd1, 0, DRET);
      bset();
      sel_hart = 2;
      rd_chk('h100, DRET, "R5 code word 0");
      chk("R5 busy cleared", 32'(busy), 32'h0);
      chk("R5 hart 2 resumed", 32'(halted), 32'h2);
      tw(2'd1, 0, 32'h0);

      // R6 sticky error
      rd_chk('h300, 32'h0, "R6 exc fetch");
      chk("R6 exception recorded", 32'(err_code), 32'h3);
      ecmd(3'd2);
      chk("R6 error not overwritten", 32'(err_code), 32'h3);
      eclr();
      chk("R6 error cleared", 32'(err_code), 32'h0);
      ecmd(3'd2);
      chk("R6 posted error", 32'(err_code), 32'h2);
      rd_chk('h304, 32'h0, "R6 exc fetch 2");
      chk("R6 exception does not override", 32'(err_code), 32'h2);
      eclr();

      // R7 byte lanes
      wr('h20C, 4'b0101, 32'h1122_3344);
      rd_chk('h20C, 32'h0022_0044, "R7 lanes 0 and 2");
      wr('h208, 4'b0001, 32'h0000_00AB);
      rd_chk('h208, 32'h0000_00AB, "R7 lane 0 is low byte");
      wr('h20C, 4'b1000, 32'h99FF_FFFF);
      rd_chk('h20C, 32'h9922_0044, "R7 lane 3 is high byte");

      // R9 table write windows
      tw(2'd3, 0, 32'hDEAD_BEEF);
      rd_chk('h000, SELF, "R9 win 3 leaves entry");
      rd_chk('h100, 32'h0, "R9 win 3 leaves code");
      rd_chk('h200, 32'h0, "R9 win 3 leaves pbuf");
      tw(2'd2, 1, 32'h0000_5555);
      rd_chk('h304, 32'h0000_5555, "R9 exc window write");
      eclr();

      // R9 and R10 same-cycle priority against restore
      sel_hart = 1;
      tw(2'd0, 1, 32'h0BAD_F00D);
      rd_chk('h004, 32'h0BAD_F00D, "R9 arm marker");
      @(negedge clk);
      m_req = 1; m_we = 0; m_addr = AW'('h200);
      tw_we = 1; tw_win = 2'd0; tw_idx = 1; tw_data = 32'h0000_1111;
      nxt_we = 1; nxt_data = 32'h0000_2222;
      @(negedge clk);
      m_req = 0; tw_we = 0; nxt_we = 0;
      rd_chk('h004, 32'h0000_1111, "R9 table write beats restore");
      rd_chk('h200, 32'h0, "R10 restore fetch");
      rd_chk('h004, 32'h0000_2222, "R10 pending write beats reset");

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule